// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block drives one pulse-width-modulated output from an 8-bit period timer. The timer is extended to a 10-bit time base by two low-order bits. Software sets an 8-bit period value, a prescale choice and a 10-bit duty value. The duty value arrives as an 8-bit upper part and a 2-bit lower part, and both parts may change at any moment.

The written duty value is not used directly. It is copied into a shadow register only when a period ends, so a new duty takes effect cleanly at the start of the following period. The output rises at the start of each period and falls when the 10-bit time base reaches the shadowed duty value.

Top module: `pwm_dbuf_gen`

## Requirements
- R1: One PWM period lasts (period_val + 1) × 4 × prescale input clock cycles. The timer counts 0..period_val and returns to 0 on the tick after it equals period_val.
- R2: psc_sel selects the prescale: 2'b00 gives 1, 2'b01 gives 4, and 2'b10 or 2'b11 gives 16.
- R3: If the duty value latched at a period start is zero, pwm_out stays low for that entire period.
- R4: The duty value is {duty_hi, duty_lo}: duty_hi forms bits 9:2 and duty_lo forms bits 1:0.
- R5: A duty change made during a period has no effect on that period. It applies from the next period start on.
- R6: For a latched duty D with 0 < D < 4 × (period_val + 1), pwm_out is high for exactly D × prescale cycles at the start of each period and low for the rest of it.
- R7: For a latched duty D ≥ 4 × (period_val + 1), pwm_out stays high through the whole period and across period boundaries.
- R8: With a nonzero latched duty, pwm_out is high in the first cycle of every period.
- R9: While en is low, pwm_out is low and the timer and prescaler are held at zero. In the first cycle with en high, a period starts using the current duty inputs.
- R10: While the synchronous reset rst is high, pwm_out is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the block idle with the output low |
| psc_sel | input | 2 | Prescale select (00: 1, 01: 4, 1x: 16) |
| period_val | input | 8 | Period register value |
| duty_hi | input | 8 | Upper 8 bits of the duty value |
| duty_lo | input | 2 | Lower 2 bits of the duty value |
| pwm_out | output | 1 | PWM output |

## Verification
The main function is exercised with period, duty and prescale combinations in which the duty is:
- a fraction of the period,
- zero,
- exactly the period length,
- far above the period length,
- equal to one.

Each combination is run over two back-to-back periods. High-cycle counts separate a wrong prescale step or wrong low-bit source from a wrong compare point, and the first sample of each period shows whether the output was set at the period start. Prescale code 2'b11 is tried separately from 2'b10 to confirm that both select the 16 divide. A mid-period write to both duty fields, followed by a write of zero, distinguishes true double buffering from a duty value that is applied immediately.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

    localparam int TMR_W     = 8;
    localparam int FRAC_W    = 2;
    localparam int PRE_W     = 3 * FRAC_W;
    localparam int DUTY_W    = TMR_W + FRAC_W;

    typedef enum logic [1:0] {
        PSC_DIV1   = 2'b00,
        PSC_DIV4   = 2'b01,
        PSC_DIV16  = 2'b10,
        PSC_DIV16B = 2'b11
    } psc_e;

    typedef struct packed {
        logic [TMR_W-1:0]  tmr;
        logic [FRAC_W-1:0] frac;
    } tbase_t;

    // Timer advances when every prescaler bit in use is at its maximum.
    function automatic logic pre_rollover(input psc_e sel, input logic [PRE_W-1:0] cnt);
        case (sel)
            PSC_DIV1: return &cnt[FRAC_W-1:0];
            PSC_DIV4: return &cnt[2*FRAC_W-1:0];
            default:  return &cnt;
        endcase
    endfunction

    // Low bits of the time base: phase bits at 1:1, top prescaler bits otherwise.
    function automatic logic [FRAC_W-1:0] frac_pick(input psc_e sel, input logic [PRE_W-1:0] cnt);
        case (sel)
            PSC_DIV1: return cnt[FRAC_W-1:0];
            PSC_DIV4: return cnt[2*FRAC_W-1:FRAC_W];
            default:  return cnt[3*FRAC_W-1:2*FRAC_W];
        endcase
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W = PRE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  psc_e              sel,
    output logic              tick,
    output logic [FRAC_W-1:0] frac
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        tick = en && pre_rollover(sel, cnt_q);
        frac = frac_pick(sel, cnt_q);
    end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_dbuf_pkg::*;
#(
    parameter int W = TMR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         tick,
    input  logic [W-1:0] period,
    output logic [W-1:0] tmr,
    output logic         wrap
);

    logic [W-1:0] tmr_q;

    assign wrap = tick && (tmr_q == period);
    assign tmr  = tmr_q;

    always_ff @(posedge clk) begin
        if (rst || !en)
            tmr_q <= '0;
        else if (wrap)
            tmr_q <= '0;
        else if (tick)
            tmr_q <= tmr_q + 1'b1;
    end

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (en && tick && tmr_q == period) |=> (tmr_q == '0)); // R1

    AST_TMR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(tmr_q) || !$past(en)); // R1

endmodule

// File: rtl/pwm_duty_stage.sv
module pwm_duty_stage
    import pwm_dbuf_pkg::*;
#(
    parameter int W = DUTY_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         wrap,
    input  logic [W-1:0] duty_in,
    input  tbase_t       tb,
    output logic         pwm_out
);

    tbase_t shadow_q;
    logic   hi_q;
    logic   load;
    logic   at_duty;

    assign load    = !en || wrap;
    assign at_duty = (tb == shadow_q);
    assign pwm_out = en && hi_q && !at_duty;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            hi_q     <= 1'b0;
        end else if (load) begin
            shadow_q <= tbase_t'(duty_in);
            hi_q     <= (duty_in != '0);
        end else if (at_duty) begin
            hi_q     <= 1'b0;
        end
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && !wrap) |=> $stable(shadow_q)); // R5

    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (rst)
        (en && wrap && duty_in == '0) |=> !pwm_out); // R3

    AST_NO_REGLITCH: assert property (@(posedge clk) disable iff (rst)
        (en && !wrap && !pwm_out) |=> !pwm_out); // R6

    AST_START_HIGH: assert property (@(posedge clk) disable iff (rst)
        (en && wrap && duty_in != '0) |=> (pwm_out || !en)); // R8

endmodule

// File: rtl/pwm_dbuf_gen.sv
module pwm_dbuf_gen
    import pwm_dbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [1:0]        psc_sel,
    input  logic [TMR_W-1:0]  period_val,
    input  logic [TMR_W-1:0]  duty_hi,
    input  logic [FRAC_W-1:0] duty_lo,
    output logic              pwm_out
);

    psc_e              sel;
    logic              tick;
    logic [FRAC_W-1:0] frac;
    logic [TMR_W-1:0]  tmr;
    logic              wrap;
    tbase_t            tb;

    assign sel     = psc_e'(psc_sel);
    assign tb.tmr  = tmr;
    assign tb.frac = frac;

    pwm_prescaler #(.CNT_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .sel  (sel),
        .tick (tick),
        .frac (frac)
    );

    pwm_timebase #(.W(TMR_W)) u_tb (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .tick   (tick),
        .period (period_val),
        .tmr    (tmr),
        .wrap   (wrap)
    );

    pwm_duty_stage #(.W(DUTY_W)) u_duty (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .wrap    (wrap),
        .duty_in ({duty_hi, duty_lo}),
        .tb      (tb),
        .pwm_out (pwm_out)
    );

    AST_DIS_LOW: assert property (@(posedge clk) disable iff (rst)
        !en |-> !pwm_out); // R9

    AST_RST_LOW: assert property (@(posedge clk)
        rst |=> !pwm_out || en); // R10

endmodule

// File: tb/pwm_dbuf_gen_test.sv
module pwm_dbuf_gen_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       en;
    logic [1:0] psc_sel;
    logic [7:0] period_val;
    logic [7:0] duty_hi;
    logic [1:0] duty_lo;
    logic       pwm_out;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pwm_dbuf_gen uut (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .psc_sel    (psc_sel),
        .period_val (period_val),
        .duty_hi    (duty_hi),
        .duty_lo    (duty_lo),
        .pwm_out    (pwm_out)
    );

    typedef struct packed {
        logic [7:0]  per;
        logic [9:0]  duty;
        logic [1:0]  psc;
        logic [15:0] hi;
        logic [15:0] len;
    } vec_t;

    // period, duty, prescale code, expected high cycles, period length in cycles
    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'd3, 10'd6,   2'b00, 16'd6,  16'd16},
        '{8'd3, 10'd6,   2'b01, 16'd24, 16'd64},
        '{8'd1, 10'd5,   2'b10, 16'd80, 16'd128},
        '{8'd4, 10'd0,   2'b00, 16'd0,  16'd20},
        '{8'd2, 10'd12,  2'b00, 16'd12, 16'd12},
        '{8'd2, 10'd200, 2'b01, 16'd48, 16'd48},
        '{8'd0, 10'd1,   2'b00, 16'd1,  16'd4},
        '{8'd9, 10'd39,  2'b00, 16'd39, 16'd40},
        '{8'd0, 10'd2,   2'b11, 16'd32, 16'd64}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Samples n consecutive cycles, starting in the current one; ends at a falling edge.
    task automatic measure(input int n, output int hi, output bit first);
        hi = 0;
        first = 1'b0;
        for (int k = 0; k < n; k++) begin
            #1;
            if (k == 0) first = pwm_out;
            if (pwm_out) hi++;
            @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int  hi;
        bit  first;

        rst = 1'b1; en = 1'b1; psc_sel = 2'b00;
        period_val = 8'd3; duty_hi = 8'd1; duty_lo = 2'd0;
        repeat (3) @(negedge clk);
        #1;
        check(pwm_out == 1'b0, "R10 output during reset", pwm_out, 0);
        @(negedge clk);
        rst = 1'b0; en = 1'b0;
        @(negedge clk);
        #1;
        check(pwm_out == 1'b0, "R9 output while disabled", pwm_out, 0);

        // Table walk: each entry over two back-to-back periods.
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            en = 1'b0;
            period_val = VECS[v].per;
            {duty_hi, duty_lo} = VECS[v].duty;
            psc_sel = VECS[v].psc;
            @(negedge clk);
            en = 1'b1;
            for (int p = 0; p < 2; p++) begin
                measure(int'(VECS[v].len), hi, first);
                check(hi == int'(VECS[v].hi), "R1 R2 R4 R6 R7 high cycles per period", hi, int'(VECS[v].hi));
                check(first == (VECS[v].duty != 10'd0), "R8 R3 output at period start",
                      first, int'(VECS[v].duty != 10'd0));
            end
        end

        // Mid-period writes: period 32 cycles at 1:1, duty 8.
        en = 1'b0;
        period_val = 8'd7; psc_sel = 2'b00;
        duty_hi = 8'd2; duty_lo = 2'd0;
        @(negedge clk);
        en = 1'b1;
        measure(10, hi, first);
        check(hi == 8, "R6 initial duty before write", hi, 8);
        duty_hi = 8'd5; duty_lo = 2'd1;            // 21
        measure(22, hi, first);
        check(hi == 0, "R5 write ignored for rest of period", hi, 0);
        measure(32, hi, first);
        check(hi == 21, "R5 R4 new duty in next period", hi, 21);
        duty_hi = 8'd0; duty_lo = 2'd0;
        measure(32, hi, first);
        check(hi == 21, "R5 zero write held off one period", hi, 21);
        measure(32, hi, first);
        check(hi == 0, "R3 zero duty keeps output low", hi, 0);

        // Disable in the middle of a high phase.
        duty_hi = 8'd7; duty_lo = 2'd3;            // 31
        measure(32, hi, first);
        measure(5, hi, first);
        check(hi == 5, "R6 high before disable", hi, 5);
        en = 1'b0;
        #1;
        check(pwm_out == 1'b0, "R9 disable drops output at once", pwm_out, 0);
        @(negedge clk);
        measure(6, hi, first);
        check(hi == 0, "R9 stays low while disabled", hi, 0);
        en = 1'b1;
        measure(32, hi, first);
        check(hi == 31, "R9 restart uses current duty", hi, 31);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule